// File: doc/BRIEF.md
# Serial Command-Stream Receiver

This block is the receiving end of a two-wire serial control port (I2C, write direction only). A fast system clock oversamples the bus clock and data lines, and edge detection runs in the system clock domain. The block finds start and stop conditions and compares the first byte of each transfer with a fixed device address. After a match it acknowledges that byte and every byte that follows. Each of those bytes goes out on a byte-wide port together with a one-cycle strobe.

No register pointer is kept. Each command byte carries its own function prefix, and the logic downstream decodes it. A transfer is one address byte followed by any number of command bytes, and a stop ends it. The block has no read path. It does not stretch the clock and does not answer a general call or a 10-bit address. The system clock must run at least 16 times the bus bit rate, and the bus bit rate may be up to 400 kbit/s.

Top module: `ctrl_i2c_rx`

## Requirements
- R1: While reset is asserted and directly after it, `sda_pull_o` is 0 (line released) and `cmd_valid_o` is 0.
- R2: A start is the data line falling while the clock line is high. A stop is the data line rising while the clock line is high. Data bits are taken at clock rising edges, most significant bit first, 8 per byte.
- R3: If the first byte after a start holds `DEV_ADDR` in bits 7..1 and a 0 in bit 0, the block pulls the data line low (`sda_pull_o` = 1) for the whole high period of the ninth clock.
- R4: If bits 7..1 of the address byte differ from `DEV_ADDR`, or bit 0 is 1, the block gives no acknowledge. It then ignores all traffic until the next start: no acknowledge and no strobe.
- R5: After a matched address, every later byte is acknowledged on its ninth clock. Any number of such bytes may come before the stop.
- R6: Each byte that follows the address appears on `cmd_data_o` while `cmd_valid_o` is high for exactly one system clock cycle. That cycle comes after the falling clock edge that ends the byte's ninth clock, never before that edge.
- R7: A start that arrives in the middle of a byte, or in the middle of a transfer, drops the partial byte and begins address reception again.
- R8: A stop in the middle of a byte drops the partial bits. No strobe is issued, the line is released, and the next transfer is received correctly.
- R9: `sda_pull_o` is 0 during the eight data bits of every byte. It changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the bus bit rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as sampled |
| sda_i | input | 1 | Bus data line as sampled (wired-AND level) |
| sda_pull_o | output | 1 | 1 = pull the data line low (open-drain enable) |
| cmd_data_o | output | 8 | Last received command byte |
| cmd_valid_o | output | 1 | One-cycle strobe marking a new byte on `cmd_data_o` |

## Verification
On every cycle the assertions check that the strobe lasts one cycle and comes only while the bus clock is low. They also check that the pull-down changes only with the clock low, and that start and stop release the line and suppress the strobe. They check that the ignoring state never acknowledges. Only the bench scenarios can show that address matching and the direction bit decide the acknowledge, and that command bytes arrive intact and in order, most significant bit first. The same goes for a repeated start mid-byte, which leads to a clean new address phase, and for a stop mid-byte, which drops the partial bits without disturbing the next transfer.

// File: rtl/ctrl_i2c_pkg.sv
package ctrl_i2c_pkg;

   localparam int unsigned BYTE_BITS = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_DATA,
      ST_DATA_ACK,
      ST_SKIP
   } rx_state_t;

endpackage

// File: rtl/ctrl_i2c_sync.sv
// Multi-stage synchronizer with one extra delayed copy for edge detection.
module ctrl_i2c_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o,
   output logic prev_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ctrl_i2c_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] chain;

   for (genvar g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RESET_VAL;
            else        chain[g] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RESET_VAL;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign sync_o = chain[STAGES-1];
   assign prev_o = chain[STAGES];

endmodule

// File: rtl/ctrl_i2c_cond.sv
// Bus event decoder: clock edges plus start / stop conditions.
module ctrl_i2c_cond (
   input  logic scl_s,
   input  logic scl_p,
   input  logic sda_s,
   input  logic sda_p,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_steady_hi;

   assign scl_steady_hi = scl_s & scl_p;
   assign scl_rise      = scl_s & ~scl_p;
   assign scl_fall      = ~scl_s & scl_p;
   assign start_det     = scl_steady_hi & sda_p & ~sda_s;
   assign stop_det      = scl_steady_hi & ~sda_p & sda_s;

endmodule

// File: rtl/ctrl_i2c_shift.sv
// Serial-in shift register with bit counter, MSB first.
module ctrl_i2c_shift #(
   parameter int unsigned WIDTH = ctrl_i2c_pkg::BYTE_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             shift_i,
   input  logic             bit_i,
   output logic [WIDTH-1:0] word_o,
   output logic             full_o
);

   localparam int unsigned CW = $clog2(WIDTH + 1);

   if (WIDTH < 2) begin : g_bad_width
      $error("ctrl_i2c_shift: WIDTH must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         word_o <= '0;
      end else if (clr_i) begin
         cnt    <= '0;
      end else if (shift_i) begin
         cnt    <= cnt + CW'(1);
         word_o <= {word_o[WIDTH-2:0], bit_i};
      end
   end

   assign full_o = (cnt == CW'(WIDTH));

endmodule

// File: rtl/ctrl_i2c_rx.sv
// Write-only serial control receiver: address match, acknowledge, byte strobe.
module ctrl_i2c_rx #(
   parameter logic [6:0]  DEV_ADDR    = 7'h44,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_pull_o,
   output logic [7:0] cmd_data_o,
   output logic       cmd_valid_o
);

   import ctrl_i2c_pkg::*;

   localparam int unsigned BW = BYTE_BITS;

   if (BW != 8) begin : g_bad_byte
      $error("ctrl_i2c_rx: byte width must be 8");
   end

   logic scl_s, scl_p, sda_s, sda_p;
   logic scl_rise, scl_fall, start_det, stop_det;
   logic shift_en, shift_clr, byte_full;
   logic [BW-1:0] rx_word;
   logic addr_hit;
   rx_state_t state;

   ctrl_i2c_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .async_i(scl_i), .sync_o(scl_s), .prev_o(scl_p)
   );

   ctrl_i2c_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .async_i(sda_i), .sync_o(sda_s), .prev_o(sda_p)
   );

   ctrl_i2c_cond u_cond (
      .scl_s(scl_s), .scl_p(scl_p), .sda_s(sda_s), .sda_p(sda_p),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   assign shift_en  = ((state == ST_ADDR) || (state == ST_DATA)) && scl_rise && !byte_full;
   assign shift_clr = start_det || stop_det || (scl_fall && byte_full);

   ctrl_i2c_shift #(.WIDTH(BW)) u_shift (
      .clk(clk), .rst_n(rst_n), .clr_i(shift_clr), .shift_i(shift_en),
      .bit_i(sda_s), .word_o(rx_word), .full_o(byte_full)
   );

   assign addr_hit = (rx_word[BW-1:1] == DEV_ADDR) && !rx_word[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         sda_pull_o  <= 1'b0;
         cmd_valid_o <= 1'b0;
         cmd_data_o  <= '0;
      end else begin
         cmd_valid_o <= 1'b0;
         if (start_det) begin
            state      <= ST_ADDR;
            sda_pull_o <= 1'b0;
         end else if (stop_det) begin
            state      <= ST_IDLE;
            sda_pull_o <= 1'b0;
         end else begin
            case (state)
               ST_ADDR: begin
                  if (scl_fall && byte_full) begin
                     if (addr_hit) begin
                        state      <= ST_ADDR_ACK;
                        sda_pull_o <= 1'b1;
                     end else begin
                        state      <= ST_SKIP;
                     end
                  end
               end
               ST_DATA: begin
                  if (scl_fall && byte_full) begin
                     state      <= ST_DATA_ACK;
                     sda_pull_o <= 1'b1;
                     cmd_data_o <= rx_word;
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     state      <= ST_DATA;
                     sda_pull_o <= 1'b0;
                  end
               end
               ST_DATA_ACK: begin
                  if (scl_fall) begin
                     state       <= ST_DATA;
                     sda_pull_o  <= 1'b0;
                     cmd_valid_o <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/ctrl_i2c_rx_chk.sv
module ctrl_i2c_rx_chk (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   scl_i,
   input logic                   sda_pull_o,
   input logic                   cmd_valid_o,
   input logic                   start_det,
   input logic                   stop_det,
   input ctrl_i2c_pkg::rx_state_t rx_state
);

   import ctrl_i2c_pkg::*;

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!cmd_valid_o && !sda_pull_o));

   p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |=> !cmd_valid_o);

   p_valid_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |-> !scl_i);

   p_pull_rise_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull_o) |-> !scl_i);

   p_pull_fall_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sda_pull_o) && !$past(start_det) && !$past(stop_det)) |-> !scl_i);

   p_start_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (!sda_pull_o && !cmd_valid_o));

   p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!sda_pull_o && !cmd_valid_o));

   p_skip_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_state == ST_SKIP) |-> (!sda_pull_o && !cmd_valid_o));

endmodule

bind ctrl_i2c_rx ctrl_i2c_rx_chk chk_i (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
   .cmd_valid_o(cmd_valid_o), .start_det(start_det), .stop_det(stop_det),
   .rx_state(state)
);

// File: tb/ctrl_i2c_rx_tb_top.sv
module ctrl_i2c_rx_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int QTR        = 10;            // system clocks per quarter bit
   localparam logic [6:0] ADDR = 7'h44;
   localparam logic [7:0] WR   = {ADDR, 1'b0};
   // {address byte, data byte, expect acknowledge}
   localparam logic [16:0] VEC [0:6] = '{
      {8'h88, 8'h24, 1'b1},
      {8'h88, 8'hB4, 1'b1},
      {8'h89, 8'h55, 1'b0},
      {8'h8A, 8'h13, 1'b0},
      {8'h08, 8'h62, 1'b0},
      {8'h88, 8'h00, 1'b1},
      {8'h88, 8'hFF, 1'b1}
   };

   logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
   logic sda_pull, cmd_valid;
   logic [7:0] cmd_data;
   wire  sda_line = sda_m & ~sda_pull;

   always #(CLK_PERIOD/2) clk = ~clk;

   ctrl_i2c_rx #(.DEV_ADDR(ADDR)) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_pull_o(sda_pull), .cmd_data_o(cmd_data), .cmd_valid_o(cmd_valid)
   );

   int n_chk = 0, n_bad = 0, cap_n = 0, pulse_err = 0, wd = 0;
   logic [7:0] cap [0:63];
   logic prev_v = 1'b0;
   bit pull_in_data = 1'b0, done = 1'b0;

   always @(negedge clk) begin
      if (cmd_valid) begin
         if (cap_n < 64) cap[cap_n] = cmd_data;
         cap_n++;
         if (prev_v) pulse_err++;
      end
      prev_v = cmd_valid;
   end

   always @(posedge clk) begin
      wd++;
      if (wd > 150000 && !done) begin
         n_chk++; n_bad++;
         $display("FAIL R5 watchdog expired actual=%0d expected=<150000", wd);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(QTR); scl_m = 1'b1; wq(QTR);
      sda_m = 1'b0; wq(QTR); scl_m = 1'b0; wq(QTR);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(QTR); scl_m = 1'b1; wq(QTR); sda_m = 1'b1; wq(QTR);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; wq(QTR); scl_m = 1'b1; wq(QTR);
      if (sda_pull) pull_in_data = 1'b1;
      wq(QTR); scl_m = 1'b0; wq(QTR);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack, output int cap_hi);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; wq(QTR); scl_m = 1'b1; wq(QTR);
      ack = !sda_line; cap_hi = cap_n;
      wq(QTR); scl_m = 1'b0; wq(QTR);
   endtask

   initial begin
      bit ack;
      int hi, n0;
      logic [16:0] e;
      logic [7:0] stream [0:3];
      stream[0] = 8'h07; stream[1] = 8'h6E; stream[2] = 8'hC3; stream[3] = 8'hF1;

      // R1: reset state
      wq(3);
      chk(sda_pull == 1'b0, "R1 pull in reset", sda_pull, 0);
      chk(cmd_valid == 1'b0, "R1 valid in reset", cmd_valid, 0);
      rst_n = 1'b1; wq(2);
      chk(!sda_pull && !cmd_valid, "R1 after reset", {sda_pull, cmd_valid}, 0);

      // Vector table: R2 R3 R4 R5 R6
      for (int v = 0; v < 7; v++) begin
         e  = VEC[v];
         n0 = cap_n;
         bus_start();
         send_byte(e[16:9], ack, hi);
         chk(ack == e[0], e[0] ? "R3 address ack" : "R4 address nack", ack, e[0]);
         send_byte(e[8:1], ack, hi);
         chk(ack == e[0], e[0] ? "R5 data ack" : "R4 data ignored", ack, e[0]);
         bus_stop();
         if (e[0]) begin
            chk(cap_n == n0 + 1, "R6 one strobe", cap_n - n0, 1);
            chk(cap[n0] == e[8:1], "R2 byte value", cap[n0], e[8:1]);
         end else begin
            chk(cap_n == n0, "R4 no strobe", cap_n - n0, 0);
         end
      end

      // R5 / R6: long command stream in one transfer
      n0 = cap_n;
      bus_start();
      send_byte(WR, ack, hi);
      chk(ack, "R3 stream address", ack, 1);
      for (int i = 0; i < 4; i++) begin
         send_byte(stream[i], ack, hi);
         chk(ack, "R5 stream ack", ack, 1);
         chk(hi == n0 + i, "R6 no strobe before ninth fall", hi - n0, i);
         chk(cap_n == n0 + i + 1, "R6 strobe after ninth fall", cap_n - n0, i + 1);
      end
      bus_stop();
      for (int i = 0; i < 4; i++)
         chk(cap[n0+i] == stream[i], "R5 stream order", cap[n0+i], stream[i]);

      // R7: repeated start mid-byte
      n0 = cap_n;
      bus_start();
      send_byte(WR, ack, hi);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
      bus_start();
      send_byte(WR, ack, hi);
      chk(ack, "R7 address after restart", ack, 1);
      send_byte(8'h5A, ack, hi);
      bus_stop();
      chk(cap_n == n0 + 1, "R7 partial dropped", cap_n - n0, 1);
      chk(cap[n0] == 8'h5A, "R7 byte after restart", cap[n0], 8'h5A);

      // R7 / R4: restart after an ignored address
      n0 = cap_n;
      bus_start();
      send_byte(8'h8A, ack, hi);
      chk(!ack, "R4 wrong address", ack, 0);
      bus_start();
      send_byte(WR, ack, hi);
      chk(ack, "R7 restart leaves ignore", ack, 1);
      send_byte(8'h11, ack, hi);
      bus_stop();
      chk(cap_n == n0 + 1 && cap[n0] == 8'h11, "R7 byte after ignore", cap[n0], 8'h11);

      // R8: stop mid-byte
      n0 = cap_n;
      bus_start();
      send_byte(WR, ack, hi);
      send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
      bus_stop();
      wq(QTR);
      chk(cap_n == n0, "R8 no strobe on stop", cap_n - n0, 0);
      chk(sda_pull == 1'b0, "R8 line released", sda_pull, 0);
      bus_start();
      send_byte(WR, ack, hi);
      send_byte(8'h3C, ack, hi);
      bus_stop();
      chk(cap_n == n0 + 1 && cap[n0] == 8'h3C, "R8 next transfer", cap[n0], 8'h3C);

      // R6 / R9: whole-run properties
      chk(pulse_err == 0, "R6 single-cycle strobe", pulse_err, 0);
      chk(pull_in_data == 1'b0, "R9 no pull in data bits", pull_in_data, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule